// File: doc/BRIEF.md
# Repeated Multiply-Accumulate Sequencer with Delay-Line Shift

This block runs the inner loop of one FIR or convolution output sample. A single start pulse hands it a repeat count N, a starting coefficient address, a starting data address, a data-address step mode, a product-shift mode and a saturation enable. It then performs N+1 iterations, one per clock once the first read has returned. In each iteration it reads one data word and one coefficient word over two single-cycle synchronous read ports. It forms their signed product, accumulates the product left over from the previous iteration through a selectable shifter, and writes the data word back one address higher. That write moves the delay line along by one tap.

The accumulation runs one step behind the multiply. The first iteration of a run adds whatever product was left in the product register, and the product of the last iteration stays in that register after the run ends. Software can therefore chain runs, or fold in that last product later. Moves are only performed inside a configured window of on-chip data RAM. Outside it, the iteration is a plain multiply-accumulate.

The bench's RAM models return, for a read and a write to the same address in one cycle, the contents before the write (read-first).

Top module: `tapmac_seq`

## Requirements
- R1: A start pulse is accepted only while `busy_o` is low. `busy_o` is high from the cycle after the accepted start up to the cycle before `done_o`. A start pulse, or any change on the parameter inputs, while busy has no effect on the run.
- R2: In each iteration the accumulator takes its old value plus the shifted product register, the T register takes the data word, and the product register takes the signed 16x16 product of the data word and the coefficient word.
- R3: The first coefficient read is at the start coefficient address. The address rises by one after every iteration but the last, and wraps at 16 bits.
- R4: A repeat count N gives exactly N+1 iterations. `done_o` is high for one cycle, N+2 rising edges after the edge that samples the start. At that point the last product sits in `prod_o` and has not been added, and the accumulator and product hold while idle.
- R5: For data read address A, the word read is written to address A+1 in the cycle its read data is returned.
- R6: Step mode 2'b01 raises the data address by one after each iteration, 2'b10 lowers it by one, and 2'b00 and 2'b11 hold it. Addresses wrap at the data address width.
- R7: Product-shift code 2'b00 passes the product unchanged, 2'b01 shifts left by 1, 2'b10 shifts left by 4, and 2'b11 shifts right arithmetically by 6. All are truncated to 32 bits.
- R8: `carry_o` holds the unsigned carry out of the most recent accumulate. `ovf_o` is set by a signed overflow of any accumulate and stays set until the next accepted start. With saturation enabled, an overflowing sum is replaced by 0x7FFFFFFF for a non-negative addend and by 0x80000000 for a negative one.
- R9: The move write is issued only when the read address A satisfies MOVE_LO <= A < MOVE_HI (defaults 0x200 and 0x3FF). Outside that window no write occurs and the multiply-accumulate is unchanged.
- R10: After reset the accumulator, product, T register, carry and overflow are zero, and busy, done and all RAM enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Start pulse |
| rpt_cnt_i | input | CNTW | Repeat count N (N+1 iterations) |
| coef_base_i | input | CAW | First coefficient address |
| data_base_i | input | DAW | First data address |
| step_mode_i | input | 2 | Data address step mode |
| pshift_i | input | 2 | Product-shift code |
| sat_en_i | input | 1 | Saturating accumulate enable |
| dm_rd_o | output | 1 | Data RAM read enable |
| dm_raddr_o | output | DAW | Data RAM read address |
| dm_rdata_i | input | DW | Data RAM read data, one cycle after the read |
| dm_we_o | output | 1 | Data RAM write enable (delay-line move) |
| dm_waddr_o | output | DAW | Data RAM write address |
| dm_wdata_o | output | DW | Data RAM write data |
| cm_rd_o | output | 1 | Coefficient RAM read enable |
| cm_raddr_o | output | CAW | Coefficient RAM read address |
| cm_rdata_i | input | DW | Coefficient RAM read data, one cycle after the read |
| acc_o | output | 2*DW | Accumulator |
| prod_o | output | 2*DW | Product register |
| treg_o | output | DW | T register (last data word) |
| carry_o | output | 1 | Carry of the last accumulate |
| ovf_o | output | 1 | Sticky overflow flag |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |

## Verification
Results of a run are due in a fixed number of cycles after start. Iteration k issues its reads k+1 edges after the start edge, and its move write and accumulate land one edge later. `done_o` rises N+2 edges after the start edge, when the accumulator, product, T register and flags are final. The bench drives inputs and samples outputs on falling edges. It counts rising edges from the start to the `done_o` it observes and compares that count with N+3, the start edge included. It compares the registers and the whole data RAM against a reference model only in that done cycle, then again after several idle cycles to confirm nothing moves.

// File: rtl/tapmac_pkg.sv
package tapmac_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'b00,
    STEP_UP   = 2'b01,
    STEP_DOWN = 2'b10,
    STEP_KEEP = 2'b11
  } step_e;

  typedef enum logic [1:0] {
    PSH_NONE = 2'b00,
    PSH_L1   = 2'b01,
    PSH_L4   = 2'b10,
    PSH_R6   = 2'b11
  } pshift_e;

endpackage

// File: rtl/tapmac_addr_gen.sv
module tapmac_addr_gen
  import tapmac_pkg::*;
#(
  parameter int CNTW = 8,
  parameter int CAW  = 16,
  parameter int DAW  = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [CNTW-1:0] cnt_i,
  input  logic [CAW-1:0]  caddr_i,
  input  logic [DAW-1:0]  daddr_i,
  input  step_e           step_i,
  output logic            run_o,
  output logic            last_o,
  output logic [CAW-1:0]  caddr_o,
  output logic [DAW-1:0]  daddr_o
);

  localparam logic [CNTW-1:0] CNT_ONE = CNTW'(1);
  localparam logic [CAW-1:0]  CA_ONE  = CAW'(1);
  localparam logic [DAW-1:0]  DA_ONE  = DAW'(1);

  logic            run_q, run_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic [CAW-1:0]  ca_q, ca_d;
  logic [DAW-1:0]  da_q, da_d;
  step_e           step_q, step_d;

  always_comb begin
    run_d  = run_q;
    cnt_d  = cnt_q;
    ca_d   = ca_q;
    da_d   = da_q;
    step_d = step_q;
    if (load_i) begin
      run_d  = 1'b1;
      cnt_d  = cnt_i;
      ca_d   = caddr_i;
      da_d   = daddr_i;
      step_d = step_i;
    end else if (run_q) begin
      if (cnt_q != '0) begin
        cnt_d = cnt_q - CNT_ONE;
        ca_d  = ca_q + CA_ONE;
        unique case (step_q)
          STEP_UP:   da_d = da_q + DA_ONE;
          STEP_DOWN: da_d = da_q - DA_ONE;
          default:   da_d = da_q;
        endcase
      end else begin
        run_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      ca_q   <= '0;
      da_q   <= '0;
      step_q <= STEP_HOLD;
    end else begin
      run_q  <= run_d;
      cnt_q  <= cnt_d;
      ca_q   <= ca_d;
      da_q   <= da_d;
      step_q <= step_d;
    end
  end

  assign run_o   = run_q;
  assign last_o  = (cnt_q == '0);
  assign caddr_o = ca_q;
  assign daddr_o = da_q;

  // R3: coefficient address advances by one between iterations
  assert_coef_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && !last_o) |=> (run_o && caddr_o == $past(caddr_o) + CA_ONE))
    else $error("coefficient address did not advance");

  // R4: the iteration with a zero count is the last one
  assert_last_stops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && last_o) |=> !run_o)
    else $error("run continued past the last iteration");

  // R6: hold modes keep the data address fixed
  assert_hold_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && !last_o && (step_q == STEP_HOLD || step_q == STEP_KEEP))
      |=> $stable(daddr_o))
    else $error("data address moved in a hold mode");

endmodule

// File: rtl/tapmac_pshift.sv
module tapmac_pshift
  import tapmac_pkg::*;
#(
  parameter int PW = 32
) (
  input  logic [PW-1:0] prod_i,
  input  pshift_e       mode_i,
  output logic [PW-1:0] sh_o
);

  always_comb begin
    unique case (mode_i)
      PSH_L1:  sh_o = {prod_i[PW-2:0], 1'b0};
      PSH_L4:  sh_o = {prod_i[PW-5:0], 4'b0000};
      PSH_R6:  sh_o = {{6{prod_i[PW-1]}}, prod_i[PW-1:6]};
      default: sh_o = prod_i;
    endcase
  end

endmodule

// File: rtl/tapmac_accum.sv
module tapmac_accum #(
  parameter int PW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_ovf_i,
  input  logic          en_i,
  input  logic          sat_i,
  input  logic [PW-1:0] addend_i,
  output logic [PW-1:0] acc_o,
  output logic          carry_o,
  output logic          ovf_o
);

  localparam logic [PW-1:0] MAXV = {1'b0, {(PW-1){1'b1}}};
  localparam logic [PW-1:0] MINV = {1'b1, {(PW-1){1'b0}}};

  logic [PW-1:0] acc_q, acc_d;
  logic          cy_q, cy_d;
  logic          ov_q, ov_d;
  logic [PW:0]   sum_ext;
  logic [PW-1:0] sum_w;
  logic          ov_w;

  assign sum_ext = {1'b0, acc_q} + {1'b0, addend_i};
  assign sum_w   = sum_ext[PW-1:0];
  assign ov_w    = (acc_q[PW-1] == addend_i[PW-1]) && (sum_w[PW-1] != acc_q[PW-1]);

  always_comb begin
    acc_d = acc_q;
    cy_d  = cy_q;
    ov_d  = ov_q;
    if (clr_ovf_i) begin
      ov_d = 1'b0;
    end
    if (en_i) begin
      cy_d = sum_ext[PW];
      if (ov_w) begin
        ov_d  = 1'b1;
        acc_d = sat_i ? (addend_i[PW-1] ? MINV : MAXV) : sum_w;
      end else begin
        acc_d = sum_w;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cy_q  <= 1'b0;
      ov_q  <= 1'b0;
    end else begin
      acc_q <= acc_d;
      cy_q  <= cy_d;
      ov_q  <= ov_d;
    end
  end

  assign acc_o   = acc_q;
  assign carry_o = cy_q;
  assign ovf_o   = ov_q;

  // R8: a saturating overflow leaves a clamp value
  assert_sat_clamp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && sat_i && ov_w) |=> (acc_o == MAXV || acc_o == MINV))
    else $error("saturated sum is not a clamp value");

  // R8: overflow flag is sticky between starts
  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !clr_ovf_i) |=> ovf_o)
    else $error("overflow flag dropped without a start");

  // R4: the accumulator holds when no iteration is retiring
  assert_acc_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(acc_o))
    else $error("accumulator changed while idle");

endmodule

// File: rtl/tapmac_seq.sv
module tapmac_seq
  import tapmac_pkg::*;
#(
  parameter int              DW      = 16,
  parameter int              CAW     = 16,
  parameter int              DAW     = 10,
  parameter int              CNTW    = 8,
  parameter logic [DAW-1:0]  MOVE_LO = 10'h200,
  parameter logic [DAW-1:0]  MOVE_HI = 10'h3FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CNTW-1:0]   rpt_cnt_i,
  input  logic [CAW-1:0]    coef_base_i,
  input  logic [DAW-1:0]    data_base_i,
  input  logic [1:0]        step_mode_i,
  input  logic [1:0]        pshift_i,
  input  logic              sat_en_i,
  output logic              dm_rd_o,
  output logic [DAW-1:0]    dm_raddr_o,
  input  logic [DW-1:0]     dm_rdata_i,
  output logic              dm_we_o,
  output logic [DAW-1:0]    dm_waddr_o,
  output logic [DW-1:0]     dm_wdata_o,
  output logic              cm_rd_o,
  output logic [CAW-1:0]    cm_raddr_o,
  input  logic [DW-1:0]     cm_rdata_i,
  output logic [2*DW-1:0]   acc_o,
  output logic [2*DW-1:0]   prod_o,
  output logic [DW-1:0]     treg_o,
  output logic              carry_o,
  output logic              ovf_o,
  output logic              busy_o,
  output logic              done_o
);

  localparam int             PW     = 2 * DW;
  localparam logic [DAW-1:0] DA_ONE = DAW'(1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  // issue stage
  logic           run_w, last_w, start_ok;
  logic [CAW-1:0] caddr_w;
  logic [DAW-1:0] daddr_w;

  tapmac_addr_gen #(.CNTW(CNTW), .CAW(CAW), .DAW(DAW)) u_addr (
    .clk     (clk),
    .rst_n   (rst_ni),
    .load_i  (start_ok),
    .cnt_i   (rpt_cnt_i),
    .caddr_i (coef_base_i),
    .daddr_i (data_base_i),
    .step_i  (step_e'(step_mode_i)),
    .run_o   (run_w),
    .last_o  (last_w),
    .caddr_o (caddr_w),
    .daddr_o (daddr_w)
  );

  // execute stage registers
  logic           v2_q, v2_d;
  logic           last2_q, last2_d;
  logic [DAW-1:0] da2_q, da2_d;
  pshift_e        psh_q, psh_d;
  logic           sat_q, sat_d;
  logic [PW-1:0]  prod_q, prod_d;
  logic [DW-1:0]  t_q, t_d;
  logic           done_q, done_d;

  logic [PW-1:0]  d_ext, c_ext, mul_w, sh_w;
  logic           move_ok;

  assign busy_o   = run_w | v2_q;
  assign start_ok = start_i & ~busy_o;

  assign d_ext = {{DW{dm_rdata_i[DW-1]}}, dm_rdata_i};
  assign c_ext = {{DW{cm_rdata_i[DW-1]}}, cm_rdata_i};
  assign mul_w = $unsigned($signed(d_ext) * $signed(c_ext));

  assign move_ok = (da2_q >= MOVE_LO) && (da2_q < MOVE_HI);

  always_comb begin
    v2_d    = run_w;
    last2_d = last_w;
    da2_d   = run_w ? daddr_w : da2_q;
    psh_d   = start_ok ? pshift_e'(pshift_i) : psh_q;
    sat_d   = start_ok ? sat_en_i : sat_q;
    prod_d  = v2_q ? mul_w : prod_q;
    t_d     = v2_q ? dm_rdata_i : t_q;
    done_d  = v2_q & last2_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      v2_q    <= 1'b0;
      last2_q <= 1'b0;
      da2_q   <= '0;
      psh_q   <= PSH_NONE;
      sat_q   <= 1'b0;
      prod_q  <= '0;
      t_q     <= '0;
      done_q  <= 1'b0;
    end else begin
      v2_q    <= v2_d;
      last2_q <= last2_d;
      da2_q   <= da2_d;
      psh_q   <= psh_d;
      sat_q   <= sat_d;
      prod_q  <= prod_d;
      t_q     <= t_d;
      done_q  <= done_d;
    end
  end

  tapmac_pshift #(.PW(PW)) u_pshift (
    .prod_i (prod_q),
    .mode_i (psh_q),
    .sh_o   (sh_w)
  );

  tapmac_accum #(.PW(PW)) u_accum (
    .clk       (clk),
    .rst_n     (rst_ni),
    .clr_ovf_i (start_ok),
    .en_i      (v2_q),
    .sat_i     (sat_q),
    .addend_i  (sh_w),
    .acc_o     (acc_o),
    .carry_o   (carry_o),
    .ovf_o     (ovf_o)
  );

  assign dm_rd_o    = run_w;
  assign dm_raddr_o = daddr_w;
  assign cm_rd_o    = run_w;
  assign cm_raddr_o = caddr_w;
  assign dm_we_o    = v2_q & move_ok;
  assign dm_waddr_o = da2_q + DA_ONE;
  assign dm_wdata_o = dm_rdata_i;
  assign prod_o     = prod_q;
  assign treg_o     = t_q;
  assign done_o     = done_q;

  // R5: the move lands one above the address read the cycle before
  assert_move_addr_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    dm_we_o |-> (dm_waddr_o == $past(dm_raddr_o) + DA_ONE && $past(dm_rd_o)))
    else $error("move write address does not follow the read");

  // R9: no move outside the on-chip window
  assert_move_window_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    dm_we_o |-> (dm_waddr_o > MOVE_LO && dm_waddr_o <= MOVE_HI))
    else $error("move write outside the window");

  // R4: done is a single-cycle pulse
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    done_o |=> !done_o)
    else $error("done held longer than one cycle");

  // R1: done is only seen when the block is idle
  assert_done_idle_R1: assert property (@(posedge clk) disable iff (!rst_ni)
    done_o |-> !busy_o)
    else $error("done raised while busy");

  // R2: the T register follows the data word on each retiring iteration
  assert_treg_load_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy_o && !dm_rd_o) |=> (treg_o == $past(dm_rdata_i)))
    else $error("T register missed the final data word");

endmodule

// File: tb/tapmac_seq_bench.sv
module tapmac_seq_bench;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [7:0]  cnt;
    logic [15:0] cb;
    logic [9:0]  db;
    logic [1:0]  step;
    logic [1:0]  sh;
    logic        sat;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{8'd0, 16'h0005, 10'h250, 2'b10, 2'b00, 1'b0},
    '{8'd7, 16'h0010, 10'h310, 2'b10, 2'b01, 1'b0},
    '{8'd5, 16'h0040, 10'h220, 2'b01, 2'b10, 1'b0},
    '{8'd4, 16'h0020, 10'h280, 2'b00, 2'b11, 1'b0},
    '{8'd9, 16'h00F8, 10'h3F8, 2'b10, 2'b10, 1'b1},
    '{8'd3, 16'h0030, 10'h3FE, 2'b01, 2'b00, 1'b0},
    '{8'd6, 16'h0070, 10'h150, 2'b10, 2'b01, 1'b0},
    '{8'd2, 16'hFFFE, 10'h201, 2'b11, 2'b00, 1'b0}
  };

  logic        clk, rst_n, start;
  logic [7:0]  cnt;
  logic [15:0] cb;
  logic [9:0]  db;
  logic [1:0]  step, sh;
  logic        sat;
  logic        dm_rd, dm_we, cm_rd;
  logic [9:0]  dm_raddr, dm_waddr;
  logic [15:0] dm_rdata, dm_wdata, cm_raddr, cm_rdata;
  logic [31:0] acc, prod;
  logic [15:0] treg;
  logic        carry, ovf, busy, done;

  int nchk = 0;
  int nerr = 0;

  logic [15:0] dmem [1024];
  logic [15:0] emem [1024];
  logic [15:0] cmem [256];

  logic [31:0] m_acc, m_prod;
  logic [15:0] m_t;
  logic        m_cy, m_ov;

  tapmac_seq u_tapmac_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .rpt_cnt_i(cnt),
    .coef_base_i(cb), .data_base_i(db), .step_mode_i(step),
    .pshift_i(sh), .sat_en_i(sat),
    .dm_rd_o(dm_rd), .dm_raddr_o(dm_raddr), .dm_rdata_i(dm_rdata),
    .dm_we_o(dm_we), .dm_waddr_o(dm_waddr), .dm_wdata_o(dm_wdata),
    .cm_rd_o(cm_rd), .cm_raddr_o(cm_raddr), .cm_rdata_i(cm_rdata),
    .acc_o(acc), .prod_o(prod), .treg_o(treg), .carry_o(carry),
    .ovf_o(ovf), .busy_o(busy), .done_o(done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // read-first synchronous RAM models
  always @(posedge clk) begin
    if (dm_rd) dm_rdata <= dmem[dm_raddr];
    if (dm_we) dmem[dm_waddr] <= dm_wdata;
    if (cm_rd) cm_rdata <= cmem[cm_raddr[7:0]];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] m_shift(input logic [31:0] p, input logic [1:0] m);
    case (m)
      2'b00:   return p;
      2'b01:   return {p[30:0], 1'b0};
      2'b10:   return {p[27:0], 4'h0};
      default: return {{6{p[31]}}, p[31:6]};
    endcase
  endfunction

  task automatic m_add(input logic [31:0] a, input logic s);
    logic [32:0] w;
    logic        o;
    w = {1'b0, m_acc} + {1'b0, a};
    o = (m_acc[31] == a[31]) && (w[31] != m_acc[31]);
    m_cy = w[32];
    if (o) m_ov = 1'b1;
    if (o && s) m_acc = a[31] ? 32'h8000_0000 : 32'h7FFF_FFFF;
    else        m_acc = w[31:0];
  endtask

  // reference run: reads see pre-run contents, moves applied in order
  task automatic model_run(input vec_t v);
    logic [15:0] rdv [256];
    logic [15:0] rcv [256];
    logic [9:0]  rda [256];
    logic [9:0]  da;
    logic [15:0] ca;
    da = v.db;
    ca = v.cb;
    m_ov = 1'b0;
    for (int k = 0; k <= int'(v.cnt); k++) begin
      rda[k] = da;
      rdv[k] = emem[da];
      rcv[k] = cmem[ca[7:0]];
      ca = ca + 16'd1;
      if (v.step == 2'b01)      da = da + 10'd1;
      else if (v.step == 2'b10) da = da - 10'd1;
    end
    for (int k = 0; k <= int'(v.cnt); k++) begin
      m_add(m_shift(m_prod, v.sh), v.sat);
      m_prod = 32'($signed(rdv[k]) * $signed(rcv[k]));
      m_t = rdv[k];
      if (rda[k] >= 10'h200 && rda[k] < 10'h3FF) emem[rda[k] + 10'd1] = rdv[k];
    end
  endtask

  task automatic drive(input vec_t v);
    cnt = v.cnt; cb = v.cb; db = v.db; step = v.step; sh = v.sh; sat = v.sat;
  endtask

  task automatic do_run(input vec_t v, input bit intrude, input string name);
    int cyc;
    int bad;
    vec_t other;
    model_run(v);
    @(negedge clk);
    drive(v);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    chk(busy == 1'b1, "R1", {name, " busy after start"}, 32'(busy), 32'd1);
    while (!done && cyc < 400) begin
      if (intrude && cyc == 2) begin
        other = '{8'd40, 16'h00A0, 10'h2A0, 2'b01, 2'b10, 1'b1};
        drive(other);
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk(done == 1'b1 && cyc == int'(v.cnt) + 3, "R4", {name, " done edge count"},
        32'(cyc), 32'(int'(v.cnt) + 3));
    chk(busy == 1'b0, "R1", {name, " idle at done"}, 32'(busy), 32'd0);
    chk(acc == m_acc, "R2/R7/R8", {name, " accumulator"}, acc, m_acc);
    chk(prod == m_prod, "R2/R3", {name, " product (last not added)"}, prod, m_prod);
    chk(treg == m_t, "R2", {name, " T register"}, 32'(treg), 32'(m_t));
    chk(carry == m_cy, "R8", {name, " carry"}, 32'(carry), 32'(m_cy));
    chk(ovf == m_ov, "R8", {name, " overflow"}, 32'(ovf), 32'(m_ov));
    bad = 0;
    for (int i = 0; i < 1024; i++) if (dmem[i] !== emem[i]) bad++;
    chk(bad == 0, "R5/R6/R9", {name, " data RAM mismatches"}, 32'(bad), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [31:0] a0, p0;
    for (int i = 0; i < 1024; i++) begin
      dmem[i] = 16'((i * 1237 + 91) ^ (i << 7));
      emem[i] = dmem[i];
    end
    for (int i = 0; i < 256; i++) cmem[i] = 16'(i * 2731 - 17000);
    m_acc = '0; m_prod = '0; m_t = '0; m_cy = 1'b0; m_ov = 1'b0;
    rst_n = 1'b0; start = 1'b0;
    drive('0);
    repeat (3) @(negedge clk);

    // R10: reset state
    chk(acc == 0 && prod == 0 && treg == 0, "R10", "reset registers",
        acc | prod | 32'(treg), 32'd0);
    chk({carry, ovf, busy, done} == 4'b0, "R10", "reset flags",
        32'({carry, ovf, busy, done}), 32'd0);
    chk({dm_rd, dm_we, cm_rd} == 3'b0, "R10", "reset RAM enables",
        32'({dm_rd, dm_we, cm_rd}), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // table walk
    for (int v = 0; v < NV; v++) do_run(VECS[v], 1'b0, $sformatf("vec%0d", v));

    // R1: start and parameter changes during a run are ignored
    do_run('{8'd6, 16'h0050, 10'h260, 2'b10, 2'b01, 1'b0}, 1'b1, "intrude");

    // R4: nothing changes while idle after done
    a0 = acc; p0 = prod;
    repeat (5) @(negedge clk);
    chk(acc == a0 && prod == p0 && !dm_we, "R4", "idle hold", acc, a0);

    // R8: positive saturation
    for (int i = 0; i < 16; i++) begin
      cmem[8'h80 + i] = 16'h7FFF;
      dmem[10'h100 + i] = 16'h7FFF; emem[10'h100 + i] = 16'h7FFF;
      dmem[10'h110 + i] = 16'h8000; emem[10'h110 + i] = 16'h8000;
    end
    do_run('{8'd5, 16'h0080, 10'h108, 2'b10, 2'b00, 1'b1}, 1'b0, "sat_pos");
    chk(acc == 32'h7FFF_FFFF && ovf, "R8", "positive clamp", acc, 32'h7FFF_FFFF);

    // R8: negative saturation
    do_run('{8'd6, 16'h0080, 10'h118, 2'b10, 2'b00, 1'b1}, 1'b0, "sat_neg");
    chk(acc == 32'h8000_0000 && ovf, "R8", "negative clamp", acc, 32'h8000_0000);

    // R8: same data without saturation wraps, overflow re-armed by start
    do_run('{8'd6, 16'h0080, 10'h118, 2'b10, 2'b00, 1'b0}, 1'b0, "wrap");

    // R7: each shift code after a small run
    for (int s = 0; s < 4; s++)
      do_run('{8'd3, 16'h0011, 10'h240, 2'b10, 2'(s), 1'b0}, 1'b0, $sformatf("shift%0d", s));

    // R6/R9: move window edge with upward stepping from below the window
    do_run('{8'd4, 16'h0003, 10'h1FE, 2'b01, 2'b00, 1'b0}, 1'b0, "win_low");

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule